// File: doc/BRIEF.md
# Countdown Event Timer with Maskable Interrupt

The block is a 56-bit down-counter that produces an interrupt when a programmed interval runs out. Software reaches it through a plain register port: an address, a write enable, 32-bit write data, and combinational read data. A full 56-bit interval takes two writes. The first write stages the lower 32 bits. The second write goes to a control word, which carries the upper 24 bits together with the run, repeat and commit flags. The counter steps down once for every cycle in which `tick_en` is high. A system-level divider normally drives `tick_en` at a fixed slow rate, and the shortest interval in practical use is two ticks.

When the interval runs out, a pending flag is set. In one-shot mode the counter then stops at zero. In repeat mode it reloads the last committed interval and keeps running. The interrupt line is the pending flag gated by a mask bit. Each mask change has its own write-one register, one to unmask and one to mask, so a write never needs a read-modify-write. A write-one-to-clear register acknowledges the pending flag.

Top module: `cdt_timer`

## Requirements
- R1: After reset the count, the run flag and the repeat flag read as zero, the interrupt is masked, the pending flag is clear and `irq` is low.
- R2: A write to offset 0x000 stages the low 32 interval bits. A write to offset 0x004 with bit 30 set commits {data[23:0], staged low word} to the count and to the reload value. Without bit 30, the count is left unchanged. A read of 0x000 returns count[31:0]. A read of 0x004 returns count[55:32] in bits [23:0], the run flag in bit 24 and the repeat flag in bit 28.
- R3: The count drops by one in each cycle in which the run flag and `tick_en` are both high. It holds when either of them is low.
- R4: A tick that finds the count at 1 or 0 while running sets the pending flag. In one-shot mode that tick also leaves the count at zero and clears the run flag.
- R5: In repeat mode (control bit 28), the expiring tick reloads the last committed value and the run flag stays set, so the flag rises every N ticks for an interval N.
- R6: A control write in the same cycle as a tick takes priority, and that tick is lost. A control write of zero stops the counter and keeps its count.
- R7: Writing 1 in bit 0 of offset 0x02c unmasks the interrupt. Writes to that offset with bit 0 clear have no effect.
- R8: Writing 1 in bit 0 of offset 0x030 masks the interrupt. Writes to that offset with bit 0 clear have no effect.
- R9: Writing 1 in bit 0 of offset 0x034 clears the pending flag, and writes with bit 0 clear have no effect. A read of 0x034 returns the pending flag in bit 0 and the unmasked state in bit 1.
- R10: `irq` is high exactly when the pending flag is set and the interrupt is unmasked.
- R11: When an acknowledge and an expiry fall in the same cycle, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-step enable |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first pair is an acknowledge write and the expiring tick. The bench issues the acknowledge with `tick_en` held high while the repeating count sits at 1, then expects the pending bit to read back as set and the count to be reloaded. The second pair is a control write and a tick. The bench commits a new interval in the same cycle as a tick and expects the committed value exactly, with no decrement applied.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 56;

  localparam logic [ADDR_W-1:0] OFS_LOW  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MSET = 8'h2c;
  localparam logic [ADDR_W-1:0] OFS_MCLR = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h34;

  localparam int BIT_RUN  = 24;
  localparam int BIT_RPT  = 28;
  localparam int BIT_LOAD = 30;

  typedef struct packed {
    logic low_wr;
    logic ctrl_wr;
    logic mask_set;
    logic mask_clr;
    logic ack;
  } cdt_strobe_t;
endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
  import cdt_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output cdt_strobe_t       stb
);
  always_comb begin
    stb          = '0;
    stb.low_wr   = wr_en && (addr == OFS_LOW);
    stb.ctrl_wr  = wr_en && (addr == OFS_CTRL);
    stb.mask_set = wr_en && (addr == OFS_MSET) && wr_data[0];
    stb.mask_clr = wr_en && (addr == OFS_MCLR) && wr_data[0];
    stb.ack      = wr_en && (addr == OFS_ACK)  && wr_data[0];
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
  import cdt_pkg::*;
#(
  parameter int W    = CNT_W,
  parameter int LO_W = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              low_wr,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [W-1:0]      count,
  output logic              run,
  output logic              rpt,
  output logic              expire
);
  localparam int HI_W = W - LO_W;

  logic [LO_W-1:0] stage_q, stage_d;
  logic [W-1:0]    count_q, count_d, reload_q, reload_d;
  logic            run_q, run_d, rpt_q, rpt_d;
  logic            step;

  assign step   = run_q && tick_en && !ctrl_wr;
  assign expire = step && (count_q <= W'(1));

  always_comb begin
    stage_d  = low_wr ? wr_data[LO_W-1:0] : stage_q;
    count_d  = count_q;
    reload_d = reload_q;
    run_d    = run_q;
    rpt_d    = rpt_q;
    if (ctrl_wr) begin
      run_d = wr_data[BIT_RUN];
      rpt_d = wr_data[BIT_RPT];
      if (wr_data[BIT_LOAD]) begin
        count_d  = {wr_data[HI_W-1:0], stage_q};
        reload_d = {wr_data[HI_W-1:0], stage_q};
      end
    end else if (expire) begin
      if (rpt_q) begin
        count_d = reload_q;
      end else begin
        count_d = '0;
        run_d   = 1'b0;
      end
    end else if (step) begin
      count_d = count_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      count_q  <= '0;
      reload_q <= '0;
      run_q    <= 1'b0;
      rpt_q    <= 1'b0;
    end else begin
      stage_q  <= stage_d;
      count_q  <= count_d;
      reload_q <= reload_d;
      run_q    <= run_d;
      rpt_q    <= rpt_d;
    end
  end

  assign count = count_q;
  assign run   = run_q;
  assign rpt   = rpt_q;

  assert_oneshot_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !rpt_q) |=> (!run_q && count_q == '0))
    else $error("one-shot expiry did not halt");

  assert_repeat_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rpt_q) |=> (run_q && count_q == $past(reload_q)))
    else $error("repeat expiry did not reload");

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !(run_q && tick_en)) |=> $stable(count_q))
    else $error("count moved without a tick");
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic mask_set,
  input  logic mask_clr,
  input  logic ack,
  output logic pending,
  output logic unmasked,
  output logic irq
);
  logic pend_q, pend_d, umask_q, umask_d;

  always_comb begin
    pend_d  = expire | (pend_q & ~ack);
    umask_d = umask_q;
    if (mask_set)      umask_d = 1'b1;
    else if (mask_clr) umask_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      umask_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      umask_q <= umask_d;
    end
  end

  assign pending  = pend_q;
  assign unmasked = umask_q;
  assign irq      = pend_q & umask_q;

  assert_expiry_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend_q)
    else $error("expiry lost");

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !expire) |=> !pend_q)
    else $error("ack did not clear");

  assert_mask_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_clr && !mask_set) |=> !irq)
    else $error("irq active after mask");

  assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_set |=> umask_q)
    else $error("unmask ignored");
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int HI_W = CNT_W - DATA_W;

  logic        rst_s1, rst_s2;
  cdt_strobe_t stb;
  logic [CNT_W-1:0] count;
  logic run, rpt, expire, pending, unmasked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  cdt_decode u_dec (.addr(addr), .wr_en(wr_en), .wr_data(wr_data), .stb(stb));

  cdt_counter #(.W(CNT_W), .LO_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_s2), .tick_en(tick_en),
    .low_wr(stb.low_wr), .ctrl_wr(stb.ctrl_wr), .wr_data(wr_data),
    .count(count), .run(run), .rpt(rpt), .expire(expire));

  cdt_irq u_irq (
    .clk(clk), .rst_n(rst_s2), .expire(expire),
    .mask_set(stb.mask_set), .mask_clr(stb.mask_clr), .ack(stb.ack),
    .pending(pending), .unmasked(unmasked), .irq(irq));

  always_comb begin
    rd_data = '0;
    case (addr)
      OFS_LOW:  rd_data = count[DATA_W-1:0];
      OFS_CTRL: begin
        rd_data[HI_W-1:0] = count[CNT_W-1:DATA_W];
        rd_data[BIT_RUN]  = run;
        rd_data[BIT_RPT]  = rpt;
      end
      OFS_ACK:  rd_data[1:0] = {unmasked, pending};
      default:  rd_data = '0;
    endcase
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_s2 |=> !irq)
    else $error("irq during reset");
endmodule

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];
  event mon_ev;

  cdt_timer u_dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
                   .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #10 clk = ~clk;

  // monitor: pops expected items and compares against outputs
  always @(mon_ev) begin
    item_t it;
    logic [31:0] act;
    it = sb.pop_front();
    act = it.is_irq ? {31'b0, irq} : rd_data;
    checks++;
    if (act !== it.exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
    end
  end

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string r);
    @(negedge clk);
    addr = a;
    sb.push_back('{is_irq: 1'b0, exp: e, req: r});
    #1 -> mon_ev;
    #1;
  endtask

  task automatic expect_irq(input logic e, input string r);
    @(negedge clk);
    sb.push_back('{is_irq: 1'b1, exp: {31'b0, e}, req: r});
    #1 -> mon_ev;
    #1;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input bit tk);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; tick_en = tk;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_rd(8'h04, 32'h0, "R1 ctrl");
    expect_rd(8'h00, 32'h0, "R1 count");
    expect_rd(8'h34, 32'h0, "R1 status");
    expect_irq(1'b0, "R1 irq");
    // R2/R3/R4 one-shot of 5
    bus_wr(8'h00, 32'd5, 0);
    bus_wr(8'h04, 32'h4100_0000, 0);
    expect_rd(8'h00, 32'd5, "R2 low commit");
    expect_rd(8'h04, 32'h0100_0000, "R2 ctrl readback");
    ticks(4);
    expect_rd(8'h00, 32'd1, "R3 decrement");
    expect_rd(8'h34, 32'h0, "R4 not yet pending");
    ticks(1);
    expect_rd(8'h00, 32'd0, "R4 count zero");
    expect_rd(8'h04, 32'h0, "R4 run cleared");
    expect_rd(8'h34, 32'h1, "R4 pending");
    expect_irq(1'b0, "R10 masked");
    ticks(2);
    expect_rd(8'h00, 32'd0, "R3 halted");
    // R7/R8 mask
    bus_wr(8'h2c, 32'hFFFF_FFFE, 0);
    expect_rd(8'h34, 32'h1, "R7 zero bit ignored");
    bus_wr(8'h2c, 32'h1, 0);
    expect_rd(8'h34, 32'h3, "R7 unmask");
    expect_irq(1'b1, "R10 irq high");
    bus_wr(8'h30, 32'hFFFF_FFFE, 0);
    expect_rd(8'h34, 32'h3, "R8 zero bit ignored");
    bus_wr(8'h30, 32'h1, 0);
    expect_rd(8'h34, 32'h1, "R8 mask");
    expect_irq(1'b0, "R10 irq masked");
    bus_wr(8'h2c, 32'h1, 0);
    // R9 acknowledge
    bus_wr(8'h34, 32'hFFFF_FFFE, 0);
    expect_rd(8'h34, 32'h3, "R9 zero bit ignored");
    bus_wr(8'h34, 32'h1, 0);
    expect_rd(8'h34, 32'h2, "R9 cleared");
    expect_irq(1'b0, "R10 irq after ack");
    // R2 full width, load without run
    bus_wr(8'h00, 32'hDEAD_BEEF, 0);
    bus_wr(8'h04, 32'h40AB_CDEF, 0);
    expect_rd(8'h00, 32'hDEAD_BEEF, "R2 wide low");
    expect_rd(8'h04, 32'h00AB_CDEF, "R2 wide high");
    ticks(3);
    expect_rd(8'h00, 32'hDEAD_BEEF, "R3 no run no count");
    bus_wr(8'h04, 32'h0100_0000, 0);
    expect_rd(8'h00, 32'hDEAD_BEEF, "R2 no load bit keeps count");
    expect_rd(8'h04, 32'h01AB_CDEF, "R2 run set");
    ticks(2);
    expect_rd(8'h00, 32'hDEAD_BEED, "R3 wide decrement");
    bus_wr(8'h04, 32'h0, 0);
    expect_rd(8'h04, 32'h00AB_CDEF, "R6 stop");
    ticks(2);
    expect_rd(8'h00, 32'hDEAD_BEED, "R6 stopped holds");
    // R5 repeat of 3
    bus_wr(8'h00, 32'd3, 0);
    bus_wr(8'h04, 32'h5100_0000, 0);
    ticks(2);
    expect_rd(8'h00, 32'd1, "R5 counting");
    expect_rd(8'h34, 32'h2, "R5 not yet pending");
    ticks(1);
    expect_rd(8'h00, 32'd3, "R5 reload");
    expect_rd(8'h04, 32'h1100_0000, "R5 still running");
    expect_rd(8'h34, 32'h3, "R5 pending");
    expect_irq(1'b1, "R10 repeat irq");
    bus_wr(8'h34, 32'h1, 0);
    ticks(2);
    expect_rd(8'h34, 32'h2, "R5 mid period");
    ticks(1);
    expect_rd(8'h34, 32'h3, "R5 second period");
    bus_wr(8'h34, 32'h1, 0);
    // R11 ack coincides with expiry
    ticks(2);
    expect_rd(8'h00, 32'd1, "R11 setup");
    bus_wr(8'h34, 32'h1, 1);
    expect_rd(8'h34, 32'h3, "R11 expiry wins");
    expect_rd(8'h00, 32'd3, "R11 reloaded");
    // R6 control write beats tick
    bus_wr(8'h00, 32'd10, 0);
    bus_wr(8'h04, 32'h4100_0000, 0);
    ticks(3);
    expect_rd(8'h00, 32'd7, "R6 setup");
    bus_wr(8'h04, 32'h4100_0000, 1);
    expect_rd(8'h00, 32'd10, "R6 write priority");
    bus_wr(8'h04, 32'h0, 0);
    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d expected 0 items left", sb.size());
    end
    finish_run();
  end
endmodule